// File: doc/BRIEF.md
# Dual-Line Simultaneous Audio Serializer

This block feeds a multibit audio converter that takes its left and right samples on two separate serial data lines at the same time. Both lines share one bit clock and one latch strobe. Every output edge is a fixed division of a single master clock, nominally 11.2896 MHz. The converter side therefore sets the pace: once per frame the block pulls a new stereo pair from upstream through a ready/valid handshake.

A frame lasts `FRAME_LEN` master cycles, 256 by default, which gives a 44.1 kHz sample rate. The bit clock runs at half the master rate, well below the converter's 6.4 MHz limit, and only for the 16 bits of the frame. It then stays low for the rest of the frame. One bit-clock period after the last bit, the strobe tells the converter to update its outputs.

Samples arrive as signed two's complement and leave as offset binary, where all zeros is the most negative code. If upstream has no pair ready when a frame is due, the block sends midscale and records an underrun.

Top module: `dual_line_serializer`

## Requirements
- R1: While reset is held and after it is released, bck, strobe, dat_l, dat_r and underrun are all low until the first frame begins.
- R2: s_ready is high for exactly one master cycle in every 256, starting in the first cycle after reset. A pair is taken at the clock edge that ends that cycle when s_valid is high.
- R3: Each frame starts with 16 bit-clock periods. Each period is one master cycle with bck low followed by one master cycle with bck high. bck then stays low for the rest of the frame.
- R4: dat_l and dat_r carry their own channel's 16-bit word at the same time, most significant bit first. A new bit appears when bck falls (or at frame start) and holds steady across the following rising edge.
- R5: Each output word equals the input sample with bit 15 inverted: 0x8000 gives 0x0000, 0x0000 gives 0x8000, and 0x7FFF gives 0xFFFF.
- R6: strobe is high for the two master cycles right after the 16th bit period, once per frame, and is never high while bck is high.
- R7: dat_l and dat_r are low from the end of the 16th bit until the next frame begins.
- R8: If s_valid is low when s_ready is high, the next frame sends 0x8000 on both lines. underrun then goes high and stays high until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| s_valid | input | 1 | Upstream has a stereo pair ready |
| s_left | input | 16 | Left sample, two's complement |
| s_right | input | 16 | Right sample, two's complement |
| s_ready | output | 1 | Block takes a pair this cycle |
| bck | output | 1 | Gated bit clock |
| dat_l | output | 1 | Left serial data |
| dat_r | output | 1 | Right serial data |
| strobe | output | 1 | Latch/update strobe to the converter |
| underrun | output | 1 | Sticky flag: a frame found no pair |

## Verification
Every decode comes from one frame counter. A counter that is off by one or wraps at the wrong value shows at the ports within one frame, as a handshake period other than 256 cycles or a strobe that overlaps a bit. A shift register that loads or shifts in the wrong cycle shows up as a mis-aligned or bit-reversed word in the first frame after the load. A wrong sign-bit conversion or a wrong midscale value shows up in the very first word captured. A lost underrun flag shows up one frame after a missed handshake.

// File: rtl/dls_pkg.sv
package dls_pkg;
   // per-master-cycle control strobes from the frame timer
   typedef struct packed {
      logic load;
      logic shift;
      logic bck;
      logic strobe;
   } dls_ctl_t;

   localparam int NUM_CH = 2;
endpackage

// File: rtl/dls_timing.sv
module dls_timing
   import dls_pkg::*;
#(
   parameter int SAMPLE_W  = 16,
   parameter int FRAME_LEN = 256
) (
   input  logic     clk,
   input  logic     rst_n,
   output dls_ctl_t ctl
);
   localparam int FCW = $clog2(FRAME_LEN);
   localparam logic [FCW-1:0] LAST  = FCW'(FRAME_LEN - 1);
   localparam logic [FCW-1:0] BURST = FCW'(2 * SAMPLE_W);

   logic [FCW-1:0] fcnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            fcnt <= LAST;
      else if (fcnt == LAST) fcnt <= '0;
      else                   fcnt <= fcnt + 1'b1;
   end

   logic in_burst;
   assign in_burst   = (fcnt < BURST);
   assign ctl.load   = (fcnt == LAST);
   assign ctl.bck    = in_burst & fcnt[0];
   assign ctl.shift  = in_burst & fcnt[0];
   assign ctl.strobe = (fcnt == BURST) | (fcnt == BURST + 1'b1);
endmodule

// File: rtl/dls_codec.sv
module dls_codec #(
   parameter int SAMPLE_W   = 16,
   parameter bit OFFSET_BIN = 1'b1
) (
   input  logic [SAMPLE_W-1:0] pcm_in,
   output logic [SAMPLE_W-1:0] code_out
);
   generate
      if (OFFSET_BIN) begin : g_offset
         assign code_out = {~pcm_in[SAMPLE_W-1], pcm_in[SAMPLE_W-2:0]};
      end else begin : g_twos
         assign code_out = pcm_in;
      end
   endgenerate
endmodule

// File: rtl/dls_shifter.sv
module dls_shifter #(
   parameter int SAMPLE_W = 16
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                load,
   input  logic                shift,
   input  logic [SAMPLE_W-1:0] word,
   output logic                sdata
);
   logic [SAMPLE_W-1:0] sreg;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     sreg <= '0;
      else if (load)  sreg <= word;
      else if (shift) sreg <= {sreg[SAMPLE_W-2:0], 1'b0};
   end

   assign sdata = sreg[SAMPLE_W-1];
endmodule

// File: rtl/dual_line_serializer.sv
module dual_line_serializer
   import dls_pkg::*;
#(
   parameter int SAMPLE_W   = 16,
   parameter int FRAME_LEN  = 256,
   parameter bit OFFSET_BIN = 1'b1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                s_valid,
   input  logic [SAMPLE_W-1:0] s_left,
   input  logic [SAMPLE_W-1:0] s_right,
   output logic                s_ready,
   output logic                bck,
   output logic                dat_l,
   output logic                dat_r,
   output logic                strobe,
   output logic                underrun
);
   localparam logic [SAMPLE_W-1:0] MIDSCALE =
      OFFSET_BIN ? {1'b1, {(SAMPLE_W-1){1'b0}}} : '0;

   generate
      if (SAMPLE_W < 2) begin : g_bad_w
         $error("SAMPLE_W must be at least 2");
      end
      if (FRAME_LEN < 2 * SAMPLE_W + 4) begin : g_bad_len
         $error("FRAME_LEN too short for burst plus strobe");
      end
   endgenerate

   dls_ctl_t ctl;

   dls_timing #(.SAMPLE_W(SAMPLE_W), .FRAME_LEN(FRAME_LEN)) i_timing (
      .clk(clk), .rst_n(rst_n), .ctl(ctl)
   );

   logic [NUM_CH-1:0][SAMPLE_W-1:0] pcm, code, word;
   logic [NUM_CH-1:0]               sd;

   assign pcm[0] = s_left;
   assign pcm[1] = s_right;

   for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
      dls_codec #(.SAMPLE_W(SAMPLE_W), .OFFSET_BIN(OFFSET_BIN)) i_codec (
         .pcm_in(pcm[ch]), .code_out(code[ch])
      );
      assign word[ch] = s_valid ? code[ch] : MIDSCALE;
      dls_shifter #(.SAMPLE_W(SAMPLE_W)) i_shift (
         .clk(clk), .rst_n(rst_n), .load(ctl.load), .shift(ctl.shift),
         .word(word[ch]), .sdata(sd[ch])
      );
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                     underrun <= 1'b0;
      else if (ctl.load && !s_valid)  underrun <= 1'b1;
   end

   assign s_ready = ctl.load;
   assign bck     = ctl.bck;
   assign strobe  = ctl.strobe;
   assign dat_l   = sd[0];
   assign dat_r   = sd[1];
endmodule

// File: rtl/dls_checker.sv
module dls_checker (
   input logic clk,
   input logic rst_n,
   input logic s_valid,
   input logic s_ready,
   input logic bck,
   input logic dat_l,
   input logic dat_r,
   input logic strobe,
   input logic underrun
);
   // R6
   strobe_bck_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      strobe |-> !bck);
   // R2
   ready_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      s_ready |=> !s_ready);
   // R3
   bck_half_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bck |=> !bck);
   // R4
   data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bck |-> ($stable(dat_l) && $stable(dat_r)));
   // R8
   underrun_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (s_ready && !s_valid) |=> underrun);
   // R8
   underrun_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      underrun |=> underrun);
endmodule

bind dual_line_serializer dls_checker i_dls_checker (
   .clk(clk), .rst_n(rst_n), .s_valid(s_valid), .s_ready(s_ready),
   .bck(bck), .dat_l(dat_l), .dat_r(dat_r), .strobe(strobe),
   .underrun(underrun)
);

// File: tb/test_dual_line_serializer.sv
module test_dual_line_serializer;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        s_valid = 1'b0;
   logic [15:0] s_left = '0, s_right = '0;
   logic        s_ready, bck, dat_l, dat_r, strobe, underrun;

   int checks = 0;
   int errors = 0;

   always #2 clk = ~clk;

   dual_line_serializer i_dual_line_serializer (
      .clk(clk), .rst_n(rst_n), .s_valid(s_valid), .s_left(s_left),
      .s_right(s_right), .s_ready(s_ready), .bck(bck), .dat_l(dat_l),
      .dat_r(dat_r), .strobe(strobe), .underrun(underrun)
   );

   // stereo pairs {left, right}
   localparam logic [31:0] VEC [6] = '{
      32'h0000_0000, 32'h7FFF_8000, 32'h8000_7FFF,
      32'h1234_EDCB, 32'hFFFF_0001, 32'hA5A5_5A5A
   };

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [15:0] ob(input logic [15:0] x);
      return {~x[15], x[14:0]};
   endfunction

   task automatic run_frame(input logic v, input logic [15:0] l, input logic [15:0] r,
                            input logic [15:0] el, input logic [15:0] er);
      logic [15:0] gl, gr;
      int n;
      bit bad_bck, bad_hold, bad_idle;
      bad_bck = 0; bad_hold = 0; bad_idle = 0;
      while (!s_ready) @(negedge clk);
      s_valid = v; s_left = l; s_right = r;
      @(negedge clk);
      s_valid = 1'b0;
      n = 1;
      check("R2 ready single cycle", {31'd0, s_ready}, 32'd0);
      for (int k = 0; k < 16; k++) begin
         if (bck !== 1'b0) bad_bck = 1;
         gl[15-k] = dat_l; gr[15-k] = dat_r;
         @(negedge clk); n++;
         if (bck !== 1'b1) bad_bck = 1;
         if (dat_l !== gl[15-k] || dat_r !== gr[15-k]) bad_hold = 1;
         @(negedge clk); n++;
      end
      check("R3 bck burst shape", {31'd0, bad_bck}, 32'd0);
      check("R4 data held over rising bck", {31'd0, bad_hold}, 32'd0);
      check("R4 R5 left word", {16'd0, gl}, {16'd0, el});
      check("R4 R5 right word", {16'd0, gr}, {16'd0, er});
      check("R6 strobe first cycle", {30'd0, strobe, bck}, 32'd2);
      @(negedge clk); n++;
      check("R6 strobe second cycle", {30'd0, strobe, bck}, 32'd2);
      @(negedge clk); n++;
      check("R6 strobe ends", {31'd0, strobe}, 32'd0);
      while (!s_ready) begin
         if (bck !== 1'b0 || strobe !== 1'b0 || dat_l !== 1'b0 || dat_r !== 1'b0)
            bad_idle = 1;
         @(negedge clk); n++;
      end
      check("R7 R3 idle lines low", {31'd0, bad_idle}, 32'd0);
      check("R2 frame period", n, 256);
   endtask

   initial begin : watchdog
      #200000;
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1 reset state
      check("R1 reset outputs", {27'd0, bck, strobe, dat_l, dat_r, underrun}, 32'd0);
      rst_n = 1'b1;
      check("R2 ready right after reset", {31'd0, s_ready}, 32'd1);
      foreach (VEC[i]) begin
         run_frame(1'b1, VEC[i][31:16], VEC[i][15:0], ob(VEC[i][31:16]), ob(VEC[i][15:0]));
         check("R8 no underrun with valid", {31'd0, underrun}, 32'd0);
      end
      // R8 underrun: missing pair gives midscale and sets flag
      run_frame(1'b0, 16'h1111, 16'h2222, 16'h8000, 16'h8000);
      check("R8 underrun set", {31'd0, underrun}, 32'd1);
      run_frame(1'b1, 16'h7FFF, 16'h0001, 16'hFFFF, 16'h8001);
      check("R8 underrun sticky", {31'd0, underrun}, 32'd1);
      // R1 reset again clears flag and lines
      rst_n = 1'b0;
      @(negedge clk);
      check("R1 reset clears underrun", {27'd0, bck, strobe, dat_l, dat_r, underrun}, 32'd0);
      rst_n = 1'b1;
      run_frame(1'b1, 16'hC000, 16'h4000, 16'h4000, 16'hC000);
      check("R8 clear after reset", {31'd0, underrun}, 32'd0);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule